// File: doc/BRIEF.md
# Sequential Radix-2 Unsigned Divider

This block divides one unsigned integer by another over several clock cycles and produces one quotient bit per cycle. A start pulse captures the dividend and the divisor. The block then runs one shift-and-trial-subtract step on each clock until every quotient bit is formed. At the end it holds the quotient and the remainder on its outputs and pulses a done flag for one cycle.

The datapath keeps two working registers of the operand width. One holds the partial remainder. The other starts out holding the dividend and is filled with quotient bits from the bottom as the dividend bits shift out of its top. Each step shifts the pair left by one bit and tries to subtract the divisor with a single adder. The decision uses the adder's carry-out ORed with the bit shifted out of the remainder register. When the trial fails, the shifted value is kept, so no restore cycle and no add-back are needed. A zero divisor does not stop the block: it raises a flag and lets the iterations run to their natural result.

The block fits behind a control sequencer that issues a start and waits for done. Operands only have to be valid in the start cycle.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted, and until the first accepted start after it, busy, done and the zero-divisor flag are low and quotient and remainder read zero.
- R2: A start seen while busy is low is accepted, and busy is high from the next cycle for exactly W cycles (16 with default parameters).
- R3: done is high for exactly one cycle, the cycle right after the last busy cycle, and busy is low whenever done is high.
- R4: When done is high and the divisor is nonzero, quotient equals the integer part of dividend divided by divisor.
- R5: When done is high and the divisor is nonzero, remainder equals dividend modulo divisor. During the iterations the partial remainder never reaches the divisor.
- R6: Outside busy, quotient and remainder hold their values until the next accepted start.
- R7: A start pulse while busy is ignored. The running division keeps its timing and its result, and the operands presented with the ignored pulse have no effect.
- R8: A divisor of zero sets the zero-divisor flag, which is valid from the cycle after start until the next accepted start. The run completes normally with quotient all ones and remainder equal to the dividend. A nonzero divisor leaves the flag low.
- R9: Operands are sampled only in the start cycle. Changes on the operand inputs during the iterations do not alter the result.
- R10: A start presented in the cycle where done is high is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin a division; accepted only while not busy |
| dividend | input | W | Unsigned dividend, sampled at an accepted start |
| divisor | input | W | Unsigned divisor, sampled at an accepted start |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when results become valid |
| div_by_zero | output | 1 | Set when the captured divisor is zero |
| quotient | output | W | Quotient register |
| remainder | output | W | Remainder register |

## Verification
On every cycle the assertions check the following:
- a start accepted while idle raises busy on the next cycle, and each busy run lasts exactly W cycles;
- done is a single-cycle pulse that follows busy and never overlaps it;
- the partial remainder stays below a nonzero divisor;
- the captured divisor stays unchanged while a start arrives during a run;
- results hold while the block is idle;
- a zero-divisor run ends with an all-ones quotient.

Only the bench's scenarios can show that quotient and remainder are arithmetically correct across many operand pairs and boundary values. The same holds for the results that an ignored start or operands changing mid-run would corrupt, for back-to-back runs started in the done cycle, and for the cleared state after reset.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DIV_DEFAULT_W = 16;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } div_phase_e;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/div_step.sv
// One combinational iteration: shift the remainder/quotient pair left,
// trial-subtract the divisor, keep the difference only when it fits.
module div_step #(
  parameter int W = div_pkg::DIV_DEFAULT_W
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] shifted;
  logic [W:0]   trial;
  logic         carry;
  logic         take;

  always_comb begin
    shifted = {rem_i[W-2:0], quo_i[W-1]};
    trial   = {1'b0, shifted} + {1'b0, ~dvs_i} + (W+1)'(1);
    carry   = trial[W];
    take    = carry | rem_i[W-1];
    rem_o   = take ? trial[W-1:0] : shifted;
    quo_o   = {quo_i[W-2:0], take};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int W = div_pkg::DIV_DEFAULT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  import div_pkg::*;

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign busy_o = (phase_q == PH_RUN);
  assign load_o = start && !busy_o;
  assign done_o = done_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load_o) begin
      phase_d = PH_RUN;
      cnt_d   = '0;
    end else if (busy_o) begin
      if (cnt_q == LAST) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // Independent run-length monitor for the busy window.
  logic [CW:0] busy_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + (CW+1)'(1);
    else             busy_len_q <= '0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> busy_o);
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len_q == (CW+1)'(W)));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = div_pkg::DIV_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic rst_n_s;
  logic load;
  logic step_en;

  logic [W-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic         dbz_q, dbz_d;
  logic [W-1:0] rem_nx, quo_nx;

  div_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  div_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (start),
    .load_o(load),
    .busy_o(busy),
    .done_o(done)
  );

  div_step #(.W(W)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .dvs_i(dvs_q),
    .rem_o(rem_nx),
    .quo_o(quo_nx)
  );

  assign step_en = busy;

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    dbz_d = dbz_q;
    if (load) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
      dbz_d = (divisor == '0);
    end else if (step_en) begin
      rem_d = rem_nx;
      quo_d = quo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      dbz_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      dbz_q <= dbz_d;
    end
  end

  assign quotient    = quo_q;
  assign remainder   = rem_q;
  assign div_by_zero = dbz_q;

  p_rem_below_div_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && dvs_q != '0) |-> (rem_q < dvs_q));
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start) |=> $stable(dvs_q));
  p_zero_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && div_by_zero) |-> (quotient == '1));
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         z;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] last_q, last_r;
  int run_len = 0;
  bit prev_done = 0;

  always #5 clk = ~clk;

  seq_divider #(.W(W)) i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: waits for idle, pulses start, pushes the expected result.
  task automatic issue(input logic [W-1:0] x, input logic [W-1:0] y);
    exp_t e;
    while (busy) @(negedge clk);
    if (y == '0) begin
      e.q = '1; e.r = x; e.z = 1'b1;
    end else begin
      e.q = x / y; e.r = x % y; e.z = 1'b0;
    end
    sb.push_back(e);
    start = 1'b1; dividend = x; divisor = y;
    @(negedge clk);
    start = 1'b0;
    dividend = ~x; divisor = y ^ 16'h5A5A;   // R9: operands move during run
  endtask

  // R7: a start with other operands while busy must be ignored
  task automatic poke_busy(input logic [W-1:0] x, input logic [W-1:0] y);
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    start = 1'b1; dividend = x; divisor = y;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after ignored start", busy, 1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0; prev_done = 0;
    end else begin
      if (prev_done)
        check(done == 1'b0, "R3", "done longer than one cycle", done, 0);
      if (busy) run_len++;
      if (done) begin
        check(run_len == W, "R2", "busy cycles", run_len, W);
        check(busy == 1'b0, "R3", "busy during done", busy, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R3", "done with empty scoreboard", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(quotient == e.q, e.z ? "R8" : "R4", "quotient", quotient, e.q);
          check(remainder == e.r, e.z ? "R8" : "R5", "remainder", remainder, e.r);
          check(div_by_zero == e.z, "R8", "zero flag", div_by_zero, e.z);
          last_q = e.q; last_r = e.r;
        end
        run_len = 0;
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "timeout", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && div_by_zero == 0, "R1", "flags in reset",
          {busy, done, div_by_zero}, 0);
    check(quotient == 0 && remainder == 0, "R1", "results in reset",
          {quotient, remainder}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && quotient == 0, "R1", "idle after release", {busy, quotient}, 0);

    issue(16'd100, 16'd7);          // R4 R5 basic
    issue(16'hFFFF, 16'd1);
    issue(16'hFFFF, 16'hFFFF);
    issue(16'd5, 16'd9);            // quotient zero
    issue(16'd0, 16'd3);
    issue(16'd1234, 16'd0);         // R8 zero divisor
    issue(16'hFFFE, 16'hFFFF);
    issue(16'hFFFF, 16'h8001);      // divisor above half range
    issue(16'h8000, 16'd2);
    issue(16'hFFFF, 16'd0);         // R8 zero divisor, all-ones dividend
    issue(16'd4242, 16'd17);
    poke_busy(16'd1, 16'd1);        // R7 ignored start
    issue(16'd50000, 16'd333);
    poke_busy(16'hFFFF, 16'd0);     // R7 ignored zero divisor start
    // R10: issue() called while busy starts in the done cycle
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = (i % 4 == 0) ? (lfsr >> 8) : lfsr >> (i % 12);
      issue(a, b);
    end
    while (busy || done) @(negedge clk);
    // R6: results hold while idle
    repeat (6) @(negedge clk);
    check(quotient == last_q, "R6", "quotient held", quotient, last_q);
    check(remainder == last_r, "R6", "remainder held", remainder, last_r);
    check(sb.size() == 0, "R10", "pending results", sb.size(), 0);
    // R1: reset clears after activity
    issue(16'd999, 16'd10);
    while (!done) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(quotient == 0 && remainder == 0 && div_by_zero == 0, "R1",
          "cleared by reset", {quotient, remainder}, 0);
    finished = 1;
    finish_run();
  end
endmodule